// File: doc/BRIEF.md
# Crosspoint Control Latch Bank

This block holds the committed routing state of a video crosspoint: for every output it keeps an input select, a gain bit and an enable bit. From that state it drives a one-hot switch-control array, with one row of input-select lines per output, plus a per-output gain vector and a per-output enable vector. A serial front end presents either a whole-matrix image or one single-output word, and pulses a one-cycle commit strobe. The mode input chooses which of the two is taken.

Reset is deliberately narrow. It clears only the enable bits and leaves every select and gain untouched. When the front end's full-image shift register has not been reloaded since reset, a bare commit of that same image restores the whole previous configuration. A reset therefore acts as an "all outputs off" switch that costs no routing state.

Top module: `xpt_latch_bank`

## Requirements
- R1: When `commit` is high and `full_mode` is 1 at a clock edge, every output o loads its 7-bit control group from `image[o*7 +: 7]`, so output 15 takes the most significant group and output 0 the least. Within a group, bit 6 is enable (1 = on), bit 5 is gain (1 = double, 0 = unity) and bits 4:0 are the input number. The new state is visible right after that edge.
- R2: When `commit` is high and `full_mode` is 0, `word[10:7]` names one output. Only that output loads `word[6:0]`, using the same field layout as R1. Every other output keeps its state.
- R3: `xbar_ctl[o*32 + i]` is 1 exactly when output o is enabled and its select equals i. A disabled output has all 32 of its bits clear.
- R4: `out_en[o]` and `gain_x2[o]` always show the committed enable and gain bits of output o.
- R5: A clock edge with `rst` high clears every enable bit and keeps every select and gain. This is also the power-up state.
- R6: With no commit, the committed state does not change. After reset is released, the outputs stay disabled until a commit.
- R7: Committing the unchanged full image again after a reset restores every output's previous select, gain and enable.
- R8: A commit that is presented in a cycle with `rst` high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears enables only |
| commit | input | 1 | One-cycle commit strobe (synchronized update) |
| full_mode | input | 1 | 1 = take the whole image, 0 = take the single-output word |
| image | input | 112 | Whole-matrix image, 7 bits per output |
| word | input | 11 | Single-output word: output number and 7 control bits |
| xbar_ctl | output | 512 | One-hot switch-control rows, 32 bits per output |
| gain_x2 | output | 16 | Per-output gain, 1 = double |
| out_en | output | 16 | Per-output enable |

## Verification
The bench builds the block with 4 outputs and 8 inputs. Single-output words are then 7 bits wide, so all 128 of them are swept exhaustively, and every select value, gain and enable reaches every output. Arithmetic full-image patterns, a reset taken with every output on, idle cycles, an unchanged re-commit and a commit that collides with reset cover the remaining rules against a bench-side model of the committed state.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    // Kind of load presented to the latch entries in a given cycle
    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_FULL = 2'd1,
        LD_ONE  = 2'd2
    } load_e;

    // Control group width for a given select width: select + gain + enable
    function automatic int group_width(input int sel_w);
        return sel_w + 2;
    endfunction

endpackage

// File: rtl/xpt_entry.sv
module xpt_entry
    import xpt_pkg::*;
#(
    parameter int SEL_W   = 5,
    parameter int OADDR_W = 4,
    parameter int IDX     = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  load_e              ld_kind,
    input  logic [OADDR_W-1:0] one_addr,
    input  logic [SEL_W+1:0]   full_grp,
    input  logic [SEL_W+1:0]   one_grp,
    output logic [SEL_W-1:0]   sel,
    output logic               gain,
    output logic               en
);
    localparam logic [OADDR_W-1:0] MY_ADDR = OADDR_W'(IDX);

    logic take_full;
    logic take_one;
    logic [SEL_W+1:0] next_grp;

    assign take_full = (ld_kind == LD_FULL);
    assign take_one  = (ld_kind == LD_ONE) && (one_addr == MY_ADDR);
    assign next_grp  = take_full ? full_grp : one_grp;

    // Enable flop: the only state reset touches
    always_ff @(posedge clk) begin
        if (rst) begin
            en <= 1'b0;
        end else if (take_full || take_one) begin
            en <= next_grp[SEL_W+1];
        end
    end

    // Routing flops: no reset, so routing survives it
    always_ff @(posedge clk) begin
        if (!rst && (take_full || take_one)) begin
            gain <= next_grp[SEL_W];
            sel  <= next_grp[SEL_W-1:0];
        end
    end

    // R5: reset turns the output off and keeps routing
    assert_rst_clear_R5: assert property (@(posedge clk) rst |=> !en);
    assert_rst_keep_R5: assert property (@(posedge clk)
        rst |=> ($stable(sel) && $stable(gain)));

    // R6: without a load nothing moves
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!take_full && !take_one) |=> $stable({en, gain, sel}));

    // R1: full image group lands in this entry
    assert_full_load_R1: assert property (@(posedge clk) disable iff (rst)
        take_full |=> ({en, gain, sel} == $past(full_grp)));

    // R2: addressed single word lands in this entry
    assert_one_load_R2: assert property (@(posedge clk) disable iff (rst)
        take_one |=> ({en, gain, sel} == $past(one_grp)));

endmodule

// File: rtl/xpt_decode.sv
module xpt_decode #(
    parameter int N_IN  = 32,
    parameter int SEL_W = 5
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             en,
    output logic [N_IN-1:0]  row
);
    for (genvar i = 0; i < N_IN; i++) begin : g_line
        assign row[i] = en && (sel == SEL_W'(i));
    end
endmodule

// File: rtl/xpt_latch_bank.sv
module xpt_latch_bank
    import xpt_pkg::*;
#(
    parameter int N_OUT = 16,
    parameter int N_IN  = 32,
    localparam int SEL_W   = $clog2(N_IN),
    localparam int GRP_W   = group_width(SEL_W),
    localparam int OADDR_W = $clog2(N_OUT),
    localparam int IMG_W   = N_OUT * GRP_W,
    localparam int WORD_W  = OADDR_W + GRP_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    commit,
    input  logic                    full_mode,
    input  logic [IMG_W-1:0]        image,
    input  logic [WORD_W-1:0]       word,
    output logic [N_OUT*N_IN-1:0]   xbar_ctl,
    output logic [N_OUT-1:0]        gain_x2,
    output logic [N_OUT-1:0]        out_en
);
    load_e ld_kind;

    always_comb begin
        if (!commit)        ld_kind = LD_NONE;
        else if (full_mode) ld_kind = LD_FULL;
        else                ld_kind = LD_ONE;
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [SEL_W-1:0] sel_o;
        logic [N_IN-1:0]  row_o;

        xpt_entry #(
            .SEL_W  (SEL_W),
            .OADDR_W(OADDR_W),
            .IDX    (o)
        ) u_entry (
            .clk     (clk),
            .rst     (rst),
            .ld_kind (ld_kind),
            .one_addr(word[WORD_W-1:GRP_W]),
            .full_grp(image[o*GRP_W +: GRP_W]),
            .one_grp (word[GRP_W-1:0]),
            .sel     (sel_o),
            .gain    (gain_x2[o]),
            .en      (out_en[o])
        );

        xpt_decode #(
            .N_IN (N_IN),
            .SEL_W(SEL_W)
        ) u_dec (
            .sel(sel_o),
            .en (out_en[o]),
            .row(row_o)
        );

        assign xbar_ctl[o*N_IN +: N_IN] = row_o;

        // R3: an enabled output drives exactly one line, a disabled one none
        assert_row_onehot_R3: assert property (@(posedge clk) disable iff (rst)
            $countones(row_o) == (out_en[o] ? 1 : 0));
    end

    // R8: a commit colliding with reset leaves all outputs off
    assert_rst_wins_R8: assert property (@(posedge clk)
        (rst && commit) |=> (out_en == '0));

endmodule

// File: tb/sim_xpt_latch_bank.sv
`timescale 1ns/1ps
module sim_xpt_latch_bank;
    localparam int NO   = 4;
    localparam int NI   = 8;
    localparam int SW   = 3;
    localparam int GW   = SW + 2;
    localparam int OAW  = 2;
    localparam int IMGW = NO * GW;
    localparam int WW   = OAW + GW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic commit = 1'b0;
    logic full_mode = 1'b0;
    logic [IMGW-1:0] image = '0;
    logic [WW-1:0] word = '0;
    logic [NO*NI-1:0] xbar_ctl;
    logic [NO-1:0] gain_x2;
    logic [NO-1:0] out_en;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model of the committed state
    logic [SW-1:0] m_sel [NO];
    logic          m_gain [NO];
    logic          m_en [NO];

    always #4 clk = ~clk;

    xpt_latch_bank #(.N_OUT(NO), .N_IN(NI)) u0 (
        .clk(clk), .rst(rst), .commit(commit), .full_mode(full_mode),
        .image(image), .word(word), .xbar_ctl(xbar_ctl),
        .gain_x2(gain_x2), .out_en(out_en)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_vec(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [NO*NI-1:0] e_ctl;
        logic [NO-1:0] e_en, e_gain;
        for (int o = 0; o < NO; o++) begin
            e_en[o] = m_en[o];
            e_gain[o] = m_gain[o];
            for (int i = 0; i < NI; i++)
                e_ctl[o*NI + i] = m_en[o] && (int'(m_sel[o]) == i);
        end
        check_vec({tag, " R4 enable"}, 64'(out_en), 64'(e_en));
        check_vec({tag, " R4 gain"}, 64'(gain_x2), 64'(e_gain));
        check_vec({tag, " R3 switch array"}, 64'(xbar_ctl), 64'(e_ctl));
    endtask

    function automatic logic [IMGW-1:0] make_image(input int k);
        logic [IMGW-1:0] v;
        for (int o = 0; o < NO; o++)
            v[o*GW +: GW] = GW'((k * 37 + o * 11 + 5) % 32);
        return v;
    endfunction

    task automatic commit_full(input logic [IMGW-1:0] img);
        commit = 1'b1; full_mode = 1'b1; image = img;
        step();
        commit = 1'b0;
        for (int o = 0; o < NO; o++) begin
            m_en[o]   = img[o*GW + GW - 1];
            m_gain[o] = img[o*GW + SW];
            m_sel[o]  = img[o*GW +: SW];
        end
    endtask

    task automatic commit_one(input logic [WW-1:0] w);
        int a;
        commit = 1'b1; full_mode = 1'b0; word = w;
        step();
        commit = 1'b0;
        a = int'(w[WW-1:GW]);
        m_en[a]   = w[GW-1];
        m_gain[a] = w[SW];
        m_sel[a]  = w[SW-1:0];
    endtask

    initial begin
        logic [IMGW-1:0] keep_img;
        for (int o = 0; o < NO; o++) begin
            m_en[o] = 1'b0; m_gain[o] = 1'b0; m_sel[o] = '0;
        end
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        // R5: power-up leaves every output disabled
        check_vec("R5 power-up enable", 64'(out_en), 64'(0));
        check_vec("R5 power-up switch array", 64'(xbar_ctl), 64'(0));

        // R1: arithmetic full images
        for (int k = 0; k < 32; k++) begin
            commit_full(make_image(k));
            check_all("R1 full image");
        end

        // R2: exhaustive single-output words
        for (int w = 0; w < (1 << WW); w++) begin
            commit_one(WW'(w));
            check_all("R2 single word");
        end

        // R5/R6/R7: reset with all outputs on, idle, restore
        keep_img = '0;
        for (int o = 0; o < NO; o++)
            keep_img[o*GW +: GW] = GW'(16 + ((o * 5 + 3) % 16));
        commit_full(keep_img);
        check_all("R7 setup");
        rst = 1'b1;
        step();
        rst = 1'b0;
        for (int o = 0; o < NO; o++) m_en[o] = 1'b0;
        check_all("R5 reset keeps routing");
        for (int n = 0; n < 5; n++) begin
            step();
            check_all("R6 idle after reset");
        end
        commit_full(keep_img);
        check_all("R7 recommit restores");

        // R8: commit colliding with reset is ignored
        rst = 1'b1; commit = 1'b1; full_mode = 1'b1;
        image = make_image(9) | {NO{5'b11000}};
        step();
        rst = 1'b0; commit = 1'b0;
        for (int o = 0; o < NO; o++) m_en[o] = 1'b0;
        check_all("R8 commit during reset");
        rst = 1'b1; commit = 1'b1; full_mode = 1'b0; word = 7'b0110101;
        step();
        rst = 1'b0; commit = 1'b0;
        check_all("R8 single word during reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule